// File: doc/BRIEF.md
# Converter Result Serial Read-Out Port

This block is the digital read-out stage of a sampling converter. Finished conversion results arrive in the system clock domain as a 16-bit word with a one-cycle valid strobe. A separate conversion-busy level marks when the converter is working. The block shifts the most recently completed result out on a single serial data pin, most significant bit first, under a serial clock supplied by an external reader.

The serial clock, chip select, frame strobe and busy level are asynchronous to the block. Each passes through a two-stage synchronizer, and its edges are found on the system clock. That clock must run at least four times faster than the serial clock.

A static mode input selects one of two framing schemes. In select-framed mode, the falling edge of chip select starts a read. In strobe-framed mode, chip select stays low and a frame strobe starts the read. In that mode the first shift is delayed until after one full serial-clock low phase that follows the strobe's fall.

A result is moved into a holding register only when busy falls. A read that starts while a finished result is still waiting for busy to fall is a protocol violation. The block flags it with a sticky error bit.

Top module: `crs_readout_top`

## Requirements
- R1: A frame sends the held 16-bit word most significant bit first: after k counted serial-clock rising edges (k from 0 to 15), sdo shows word bit 15-k.
- R2: In select-framed mode (mode_fs=0), a falling edge of cs_n starts a frame that shows bit 15. Every later rising edge of sclk advances the output by one bit.
- R3: After bit 0 has been shown, sdo keeps showing bit 0 on the 16th and 17th counted rising edges. From the 18th counted edge onward it shows bit 15 again and holds it.
- R4: If cs_n rises and falls again while a frame is in progress, the old frame is dropped and a new one starts at bit 15.
- R5: In strobe-framed mode (mode_fs=1, cs_n low), a rising edge of fs starts a frame that shows bit 15. Rising edges of sclk have no effect until sclk has fallen at least once after fs fell. The first rising edge after that fall shows bit 14.
- R6: In strobe-framed mode, if fs is high when busy falls, the frame restarts at bit 15 of the newly finished result.
- R7: While cs_n is high, sdo and sdo_oe are both 0.
- R8: A frame that starts while busy is high and before res_valid has been seen reads the previously completed result. A frame that starts after busy falls reads the new result.
- R9: A frame that starts after res_valid but before busy falls sets proto_err and reads the previous result. proto_err stays set until reset.
- R10: The holding register changes only when busy falls. In select-framed mode, a busy fall during a frame does not change the bit being shown or the count.
- R11: After reset the held word is zero, no frame is active, and sdo, sdo_oe and proto_err are 0.
- R12: After a cs_n fall, sdo shows the new frame's first bit by the third rising system-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_fs | input | 1 | Static framing select: 0 = chip-select framed, 1 = strobe framed |
| cs_n | input | 1 | Asynchronous active-low chip select |
| fs | input | 1 | Asynchronous frame strobe used in strobe-framed mode |
| sclk | input | 1 | Asynchronous serial clock from the reader |
| busy | input | 1 | Asynchronous conversion-busy level; its fall commits a result |
| res_data | input | 16 | Conversion result in the system clock domain |
| res_valid | input | 1 | One-cycle strobe qualifying res_data |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| proto_err | output | 1 | Sticky flag for a frame started inside the forbidden window |

## Verification
Each asynchronous input passes through two synchronizer flops, and the state is updated on the following edge. A new bit is therefore due on sdo at the third system-clock rising edge after an input change. The latency check samples at exactly that edge. Every other check lets four system clocks pass after a stimulus, one serial-clock half period, and then samples one time unit after a clock edge. Inputs are driven at the same offset, so no sample falls on an edge where the design might still be changing. Expected bits come from a formula that maps the rising-edge count to a bit index. The bench applies that formula to a sweep of computed words in both framing modes.

// File: rtl/crs_pkg.sv
package crs_pkg;
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_FSHI  = 2'd1,
        FR_WAITF = 2'd2,
        FR_SHIFT = 2'd3
    } frame_st_e;

    localparam int SIG_CS   = 0;
    localparam int SIG_FS   = 1;
    localparam int SIG_SCLK = 2;
    localparam int SIG_BUSY = 3;
    localparam int SIG_N    = 4;
endpackage

// File: rtl/crs_sync.sv
module crs_sync #(
    parameter int              W       = 4,
    parameter int              NSTAGE  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [NSTAGE-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_in;
        for (int s = 1; s < NSTAGE; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {NSTAGE{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_out = stg_q[NSTAGE-1];
endmodule

// File: rtl/crs_edge.sv
module crs_edge #(
    parameter int           W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] tog
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign tog = lvl ^ prev_q;
endmodule

// File: rtl/crs_result_store.sv
module crs_result_store #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] res_data,
    input  logic          res_valid,
    input  logic          busy_fall,
    output logic [DW-1:0] hold_next,
    output logic          win_open
);
    typedef struct packed {
        logic [DW-1:0] pend;
        logic [DW-1:0] hold;
        logic          win;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (busy_fall) begin
            st_d.hold = st_q.pend;
            st_d.win  = 1'b0;
        end
        if (res_valid) begin
            st_d.pend = res_data;
            st_d.win  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_next = st_d.hold;
    assign win_open  = st_q.win;

    AST_HOLD_ONLY_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_fall |=> $stable(st_q.hold)); // R10
    AST_WINDOW_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_fall && !res_valid) |=> !st_q.win); // R9
endmodule

// File: rtl/crs_frame_ctrl.sv
module crs_frame_ctrl
    import crs_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_fs,
    input  logic          cs_lvl,
    input  logic          cs_fall,
    input  logic          fs_lvl,
    input  logic          fs_rise,
    input  logic          fs_fall,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          busy_fall,
    input  logic [DW-1:0] hold_new,
    input  logic          win_open,
    output logic          sdo,
    output logic          sdo_oe,
    output logic          proto_err
);
    localparam int CMAX  = DW + 2;
    localparam int CNT_W = $clog2(CMAX + 1);

    typedef struct packed {
        frame_st_e      st;
        logic [DW-1:0]  word;
        logic [CNT_W-1:0] cnt;
        logic           err;
    } frame_t;

    frame_t fr_d, fr_q;
    logic [DW-1:0] shl;
    logic          bad_start;

    always_comb begin
        fr_d      = fr_q;
        bad_start = win_open && !busy_fall;
        if (cs_lvl) begin
            fr_d.st  = FR_IDLE;
            fr_d.cnt = '0;
        end else if (!mode_fs) begin
            if (cs_fall) begin
                fr_d.st   = FR_SHIFT;
                fr_d.word = hold_new;
                fr_d.cnt  = '0;
                fr_d.err  = fr_q.err | bad_start;
            end else if (fr_q.st == FR_SHIFT && sclk_rise
                         && fr_q.cnt < CNT_W'(CMAX)) begin
                fr_d.cnt = fr_q.cnt + CNT_W'(1);
            end
        end else begin
            if (fs_rise) begin
                fr_d.st   = FR_FSHI;
                fr_d.word = hold_new;
                fr_d.cnt  = '0;
                fr_d.err  = fr_q.err | bad_start;
            end else if (fs_lvl && busy_fall) begin
                fr_d.st   = FR_FSHI;
                fr_d.word = hold_new;
                fr_d.cnt  = '0;
            end else if (fr_q.st == FR_FSHI && fs_fall) begin
                fr_d.st = FR_WAITF;
            end else if (fr_q.st == FR_WAITF && sclk_fall) begin
                fr_d.st = FR_SHIFT;
            end else if (fr_q.st == FR_SHIFT && sclk_rise
                         && fr_q.cnt < CNT_W'(CMAX)) begin
                fr_d.cnt = fr_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '{st: FR_IDLE, word: '0, cnt: '0, err: 1'b0};
        end else begin
            fr_q <= fr_d;
        end
    end

    always_comb begin
        shl = fr_q.word << fr_q.cnt;
        if (cs_lvl || fr_q.st == FR_IDLE) begin
            sdo = 1'b0;
        end else if (fr_q.cnt < CNT_W'(DW)) begin
            sdo = shl[DW-1];
        end else if (fr_q.cnt < CNT_W'(DW + 2)) begin
            sdo = fr_q.word[0];
        end else begin
            sdo = fr_q.word[DW-1];
        end
    end

    assign sdo_oe    = !cs_lvl;
    assign proto_err = fr_q.err;

    AST_CNT_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_fall || fs_rise || busy_fall) |=>
        (fr_q.cnt == $past(fr_q.cnt)) || (fr_q.cnt == $past(fr_q.cnt) + CNT_W'(1))
        || (fr_q.cnt == '0)); // R2
    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.cnt <= CNT_W'(CMAX)); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.err |=> fr_q.err); // R9
    AST_FS_NO_EARLY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st == FR_FSHI && !cs_lvl && !fs_rise && !busy_fall) |=> fr_q.cnt == '0); // R5
endmodule

// File: rtl/crs_readout_top.sv
module crs_readout_top
    import crs_pkg::*;
#(
    parameter int DW     = 16,
    parameter int NSTAGE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_fs,
    input  logic          cs_n,
    input  logic          fs,
    input  logic          sclk,
    input  logic          busy,
    input  logic [DW-1:0] res_data,
    input  logic          res_valid,
    output logic          sdo,
    output logic          sdo_oe,
    output logic          proto_err
);
    localparam logic [SIG_N-1:0] IDLE_LVL = SIG_N'(1) << SIG_CS;

    logic [SIG_N-1:0] raw, lvl, tog;
    logic cs_fall, fs_rise, fs_fall, sclk_rise, sclk_fall, busy_fall;
    logic [DW-1:0] hold_next;
    logic win_open;

    always_comb begin
        raw           = '0;
        raw[SIG_CS]   = cs_n;
        raw[SIG_FS]   = fs;
        raw[SIG_SCLK] = sclk;
        raw[SIG_BUSY] = busy;
    end

    crs_sync #(.W(SIG_N), .NSTAGE(NSTAGE), .RST_VAL(IDLE_LVL)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(raw), .sync_out(lvl)
    );

    crs_edge #(.W(SIG_N), .RST_VAL(IDLE_LVL)) edge_i (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .tog(tog)
    );

    assign cs_fall   = tog[SIG_CS]   & ~lvl[SIG_CS];
    assign fs_rise   = tog[SIG_FS]   &  lvl[SIG_FS];
    assign fs_fall   = tog[SIG_FS]   & ~lvl[SIG_FS];
    assign sclk_rise = tog[SIG_SCLK] &  lvl[SIG_SCLK];
    assign sclk_fall = tog[SIG_SCLK] & ~lvl[SIG_SCLK];
    assign busy_fall = tog[SIG_BUSY] & ~lvl[SIG_BUSY];

    crs_result_store #(.DW(DW)) store_i (
        .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_valid(res_valid),
        .busy_fall(busy_fall), .hold_next(hold_next), .win_open(win_open)
    );

    crs_frame_ctrl #(.DW(DW)) frame_i (
        .clk(clk), .rst_n(rst_n), .mode_fs(mode_fs),
        .cs_lvl(lvl[SIG_CS]), .cs_fall(cs_fall),
        .fs_lvl(lvl[SIG_FS]), .fs_rise(fs_rise), .fs_fall(fs_fall),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .busy_fall(busy_fall),
        .hold_new(hold_next), .win_open(win_open),
        .sdo(sdo), .sdo_oe(sdo_oe), .proto_err(proto_err)
    );

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> (!sdo_oe && !sdo)); // R7
endmodule

// File: tb/crs_readout_top_tb_top.sv
module crs_readout_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_fs = 1'b0, cs_n = 1'b1, fs = 1'b0, sclk = 1'b0, busy = 1'b0;
    logic [15:0] res_data = '0;
    logic res_valid = 1'b0;
    logic sdo, sdo_oe, proto_err;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    crs_readout_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode_fs(mode_fs), .cs_n(cs_n), .fs(fs),
        .sclk(sclk), .busy(busy), .res_data(res_data), .res_valid(res_valid),
        .sdo(sdo), .sdo_oe(sdo_oe), .proto_err(proto_err)
    );

    function automatic logic exp_bit(input logic [15:0] w, input int k);
        if (k < 16) return w[15-k];
        else if (k < 18) return w[0];
        else return w[15];
    endfunction

    function automatic logic [15:0] sweep_word(input int i);
        return 16'((i * 40503) ^ 16'h5A5A);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic deliver(input logic [15:0] w);
        busy = 1'b1; tick(4);
        res_data = w; res_valid = 1'b1; tick(1);
        res_valid = 1'b0; tick(4);
        busy = 1'b0; tick(4);
    endtask

    task automatic cs_frame(input logic [15:0] w);
        cs_n = 1'b0; tick(4);
        chk("R2 first bit", 32'(sdo), 32'(exp_bit(w, 0)));
        chk("R7 oe when selected", 32'(sdo_oe), 32'd1);
        for (int k = 1; k <= 20; k++) begin
            sclk = 1'b1; tick(4);
            if (k < 16) chk("R1 bit order", 32'(sdo), 32'(exp_bit(w, k)));
            else chk("R3 after lsb", 32'(sdo), 32'(exp_bit(w, k)));
            sclk = 1'b0; tick(4);
        end
        cs_n = 1'b1; tick(4);
        chk("R7 sdo low deselected", 32'(sdo), 32'd0);
        chk("R7 oe low deselected", 32'(sdo_oe), 32'd0);
    endtask

    task automatic fs_frame(input logic [15:0] w);
        fs = 1'b1; tick(4);
        chk("R5 msb on fs rise", 32'(sdo), 32'(exp_bit(w, 0)));
        sclk = 1'b1; tick(4);
        chk("R5 rise while fs high ignored", 32'(sdo), 32'(exp_bit(w, 0)));
        sclk = 1'b0; tick(4);
        fs = 1'b0; tick(4);
        chk("R5 fs fall holds msb", 32'(sdo), 32'(exp_bit(w, 0)));
        sclk = 1'b1; tick(4);
        chk("R5 rise before fall ignored", 32'(sdo), 32'(exp_bit(w, 0)));
        sclk = 1'b0; tick(4);
        for (int k = 1; k <= 19; k++) begin
            sclk = 1'b1; tick(4);
            chk("R5 R1 R3 shifted bit", 32'(sdo), 32'(exp_bit(w, k)));
            sclk = 1'b0; tick(4);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] wa, wb, wc;
        tick(5);
        rst_n = 1'b1; tick(4);
        chk("R11 sdo after reset", 32'(sdo), 32'd0);
        chk("R11 oe after reset", 32'(sdo_oe), 32'd0);
        chk("R11 err after reset", 32'(proto_err), 32'd0);
        cs_n = 1'b0; tick(4);
        chk("R11 held word cleared", 32'(sdo), 32'd0);
        sclk = 1'b1; tick(4);
        chk("R11 held word cleared bit14", 32'(sdo), 32'd0);
        sclk = 1'b0; cs_n = 1'b1; tick(4);

        for (int i = 0; i < 6; i++) begin
            wa = sweep_word(i);
            deliver(wa);
            cs_frame(wa);
        end

        // R12 latency: data due at the third system clock edge
        wa = 16'hC35A;
        deliver(wa);
        cs_n = 1'b0; tick(3);
        chk("R12 msb by third edge", 32'(sdo), 32'd1);
        tick(1);
        cs_n = 1'b1; tick(4);

        // R4 abort and restart
        cs_n = 1'b0; tick(4);
        for (int k = 1; k <= 5; k++) begin
            sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
        end
        chk("R4 mid frame", 32'(sdo), 32'(exp_bit(wa, 5)));
        cs_n = 1'b1; tick(4);
        cs_n = 1'b0; tick(4);
        chk("R4 restart at msb", 32'(sdo), 32'(exp_bit(wa, 0)));
        sclk = 1'b1; tick(4);
        chk("R4 restart second bit", 32'(sdo), 32'(exp_bit(wa, 1)));
        sclk = 1'b0; cs_n = 1'b1; tick(4);

        // R8 R9 R10 read window sequence
        wa = 16'h9A3C;
        wb = ~wa;
        deliver(wa);
        busy = 1'b1; tick(4);
        cs_n = 1'b0; tick(4);
        chk("R8 early frame reads previous", 32'(sdo), 32'(exp_bit(wa, 0)));
        chk("R8 early frame no error", 32'(proto_err), 32'd0);
        cs_n = 1'b1; tick(4);
        res_data = wb; res_valid = 1'b1; tick(1);
        res_valid = 1'b0; tick(4);
        cs_n = 1'b0; tick(4);
        chk("R9 window start reads previous", 32'(sdo), 32'(exp_bit(wa, 0)));
        chk("R9 window start flags error", 32'(proto_err), 32'd1);
        for (int k = 1; k <= 3; k++) begin
            sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
        end
        chk("R10 before busy fall", 32'(sdo), 32'(exp_bit(wa, 3)));
        busy = 1'b0; tick(4);
        chk("R10 busy fall leaves frame", 32'(sdo), 32'(exp_bit(wa, 3)));
        sclk = 1'b1; tick(4);
        chk("R10 count continues", 32'(sdo), 32'(exp_bit(wa, 4)));
        sclk = 1'b0; cs_n = 1'b1; tick(4);
        cs_n = 1'b0; tick(4);
        chk("R8 late frame reads new", 32'(sdo), 32'(exp_bit(wb, 0)));
        sclk = 1'b1; tick(4);
        chk("R8 late frame bit14", 32'(sdo), 32'(exp_bit(wb, 1)));
        chk("R9 error sticky", 32'(proto_err), 32'd1);
        sclk = 1'b0; cs_n = 1'b1; tick(4);

        // strobe-framed mode
        mode_fs = 1'b1; tick(2);
        cs_n = 1'b0; tick(4);
        for (int i = 6; i < 10; i++) begin
            wa = sweep_word(i);
            deliver(wa);
            fs_frame(wa);
        end

        // R6 reload on busy fall while fs high
        wa = 16'h1234;
        wc = 16'hF00F;
        deliver(wa);
        fs = 1'b1; tick(4);
        chk("R6 before reload", 32'(sdo), 32'(exp_bit(wa, 0)));
        deliver(wc);
        chk("R6 reload new msb", 32'(sdo), 32'(exp_bit(wc, 0)));
        sclk = 1'b0; fs = 1'b0; tick(4);
        sclk = 1'b1; tick(4);
        sclk = 1'b0; tick(4);
        sclk = 1'b1; tick(4);
        chk("R6 reloaded word shifts", 32'(sdo), 32'(exp_bit(wc, 1)));
        sclk = 1'b0; cs_n = 1'b1; tick(4);
        chk("R7 strobe mode deselect", 32'(sdo_oe), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule